// File: doc/BRIEF.md
# Register-Triggered Byte Copy Engine

This block moves a run of bytes from one place in a 20-bit memory space to another. Software sets it up through a small window of byte-wide setup registers: a source address, a destination address and a 16-bit byte count. It then writes the control register with the start bit set. The engine copies the bytes one at a time, lowest address first, through a simple request/ready memory master port. Each byte is read from memory before the same byte is written.

When the last byte has been written, the engine stores the advanced source and destination offsets (the low 16 bits of each address) back into the setup registers. It also clears the count and drops the busy flag. Software can then chain a second transfer by loading a new count and starting again, without reloading the addresses. While a copy runs, control bit 7 reads as one and every register write is discarded.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset every register offset reads 0x00, control bit 7 (busy) reads 0, and `mem_req` is low.
- R2: The source address is built from offset 0 (address bits 7:0), offset 1 (bits 15:8) and offset 2 (bits 19:16 held in data bits 3:0). Each of these reads back what was written, and bits 7:4 of offset 2 read 0.
- R3: The destination address is built from offset 4 (bits 7:0), offset 5 (bits 15:8) and offset 3 (bits 19:16 in data bits 3:0, bits 7:4 read 0). The byte count is built from offset 6 (low byte) and offset 7 (high byte).
- R4: A write to offset 8 with data bit 7 set starts a copy. A write to offset 8 with bit 7 clear starts nothing. While a copy runs, offset 8 reads 0x80.
- R5: For a count N, the engine issues 2N memory transactions that alternate read then write. Read k is at source+k. Write k carries the byte returned by read k to destination+k. Addresses increment across the full 20 bits.
- R6: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R7: When a copy finishes, offsets 6, 7 and 8 read 0x00. Offsets 0/1 and 4/5 hold the low 16 bits of the start address plus N. Offsets 2 and 3 (address bits 19:16) keep the values written before the start.
- R8: A start with a count of zero issues no memory transaction. Offset 8 reads 0x80 for exactly one cycle and then 0x00.
- R9: Register writes while a copy runs have no effect, including a second start request.
- R10: Offsets 9 to 15 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset for both read and write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` (combinational) |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ready | input | 1 | Memory accepts the transaction this cycle |
| mem_rdata | input | 8 | Memory read data, valid when a read is accepted |

## Verification
The copy path is tried with five patterns, and each one separates a different fault:
- A short copy within one 64 KiB bank checks the order of transactions and the data forwarding.
- A chained follow-up copy that reloads only the count shows whether the offsets were written back.
- A copy whose source and destination cross the 0xFFFF boundary tells a full 20-bit increment apart from a 16-bit wrap, and also shows that the bank nibbles are not rewritten.
- A longer copy that is hit with register writes and a second start while busy separates ignored writes from accepted ones.
- A zero-count start tells an immediate completion apart from a transfer of 65536 bytes.

The memory responder varies its latency from zero to two wait cycles, so the hold rule for a stalled request is exercised.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

    localparam int ADDR_W = 20;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 4;
    localparam int WB_W   = 16;
    localparam int BANK_W = ADDR_W - WB_W;
    localparam int START_BIT = 7;

    localparam logic [OFS_W-1:0] OFS_SRC_LO  = 4'd0;
    localparam logic [OFS_W-1:0] OFS_SRC_MID = 4'd1;
    localparam logic [OFS_W-1:0] OFS_SRC_BNK = 4'd2;
    localparam logic [OFS_W-1:0] OFS_DST_BNK = 4'd3;
    localparam logic [OFS_W-1:0] OFS_DST_LO  = 4'd4;
    localparam logic [OFS_W-1:0] OFS_DST_MID = 4'd5;
    localparam logic [OFS_W-1:0] OFS_CNT_LO  = 4'd6;
    localparam logic [OFS_W-1:0] OFS_CNT_HI  = 4'd7;
    localparam logic [OFS_W-1:0] OFS_CTRL    = 4'd8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } xfer_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
    } xfer_cfg_t;

    function automatic logic [DATA_W-1:0] bank_to_byte(input logic [BANK_W-1:0] b);
        return {{(DATA_W-BANK_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/blkcopy_regs.sv
module blkcopy_regs
    import blkcopy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_ofs,
    input  logic              busy,
    input  logic              wb_en,
    input  logic [WB_W-1:0]   wb_src,
    input  logic [WB_W-1:0]   wb_dst,
    output xfer_cfg_t         cfg,
    output logic [DATA_W-1:0] rd_data
);

    xfer_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wb_en) begin
            cfg_q.src[WB_W-1:0] <= wb_src;
            cfg_q.dst[WB_W-1:0] <= wb_dst;
            cfg_q.cnt           <= '0;
        end else if (wr_en) begin
            case (wr_ofs)
                OFS_SRC_LO:  cfg_q.src[7:0]        <= wr_data;
                OFS_SRC_MID: cfg_q.src[15:8]       <= wr_data;
                OFS_SRC_BNK: cfg_q.src[ADDR_W-1:WB_W] <= wr_data[BANK_W-1:0];
                OFS_DST_BNK: cfg_q.dst[ADDR_W-1:WB_W] <= wr_data[BANK_W-1:0];
                OFS_DST_LO:  cfg_q.dst[7:0]        <= wr_data;
                OFS_DST_MID: cfg_q.dst[15:8]       <= wr_data;
                OFS_CNT_LO:  cfg_q.cnt[7:0]        <= wr_data;
                OFS_CNT_HI:  cfg_q.cnt[15:8]       <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_ofs)
            OFS_SRC_LO:  rd_data = cfg_q.src[7:0];
            OFS_SRC_MID: rd_data = cfg_q.src[15:8];
            OFS_SRC_BNK: rd_data = bank_to_byte(cfg_q.src[ADDR_W-1:WB_W]);
            OFS_DST_BNK: rd_data = bank_to_byte(cfg_q.dst[ADDR_W-1:WB_W]);
            OFS_DST_LO:  rd_data = cfg_q.dst[7:0];
            OFS_DST_MID: rd_data = cfg_q.dst[15:8];
            OFS_CNT_LO:  rd_data = cfg_q.cnt[7:0];
            OFS_CNT_HI:  rd_data = cfg_q.cnt[15:8];
            OFS_CTRL:    rd_data = {busy, {(DATA_W-1){1'b0}}};
            default:     rd_data = '0;
        endcase
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/blkcopy_seq.sv
module blkcopy_seq
    import blkcopy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_cfg_t         cfg_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              wb_en,
    output logic [WB_W-1:0]   wb_src,
    output logic [WB_W-1:0]   wb_dst
);

    xfer_state_t       state_q;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [CNT_W-1:0]  left_q;
    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            left_q  <= '0;
            byte_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        src_q   <= cfg_in.src;
                        dst_q   <= cfg_in.dst;
                        left_q  <= cfg_in.cnt;
                        state_q <= (cfg_in.cnt == '0) ? ST_FINISH : ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        byte_q  <= mem_rdata;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        src_q   <= src_q + 1'b1;
                        dst_q   <= dst_q + 1'b1;
                        left_q  <= left_q - 1'b1;
                        state_q <= (left_q == CNT_W'(1)) ? ST_FINISH : ST_READ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = (state_q == ST_WRITE) ? dst_q : src_q;
        mem_wdata = byte_q;
        busy      = (state_q != ST_IDLE);
        wb_en     = (state_q == ST_FINISH);
        wb_src    = src_q[WB_W-1:0];
        wb_dst    = dst_q[WB_W-1:0];
    end

endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
    import blkcopy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [OFS_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic            busy;
    logic            wb_en;
    logic [WB_W-1:0] wb_src;
    logic [WB_W-1:0] wb_dst;
    logic            reg_wr;
    logic            start;
    xfer_cfg_t       cfg_q;

    assign reg_wr = cfg_we && !busy;
    assign start  = reg_wr && (cfg_addr == OFS_CTRL) && cfg_wdata[START_BIT];

    blkcopy_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_ofs  (cfg_addr),
        .wr_data (cfg_wdata),
        .rd_ofs  (cfg_addr),
        .busy    (busy),
        .wb_en   (wb_en),
        .wb_src  (wb_src),
        .wb_dst  (wb_dst),
        .cfg     (cfg_q),
        .rd_data (cfg_rdata)
    );

    blkcopy_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_in    (cfg_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .wb_en     (wb_en),
        .wb_src    (wb_src),
        .wb_dst    (wb_dst)
    );

endmodule

// File: rtl/blkcopy_chk.sv
module blkcopy_chk
    import blkcopy_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              wb_en,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input xfer_cfg_t         cfg_val
);

    // R1: no memory traffic unless a copy is in progress
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R6: a stalled request keeps every field steady
    p_hold_req_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R5: an accepted read is followed by the matching write
    p_read_then_write_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

    // R5: an accepted write is never followed directly by another write
    p_write_then_read_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ready) |=> !(mem_req && mem_we));

    // R9: setup registers are frozen while copying, apart from the final write-back
    p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !wb_en) |=> $stable(cfg_val));

    // R7: completion leaves a zero count and an idle engine
    p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> (cfg_val.cnt == '0 && !busy));

endmodule

bind blkcopy_engine blkcopy_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .wb_en     (wb_en),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cfg_val   (cfg_q)
);

// File: tb/test_blkcopy_engine.sv
module test_blkcopy_engine;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    typedef struct {
        bit          we;
        logic [19:0] a;
        logic [7:0]  d;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ready = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    txn_t exp_q[$];
    logic [7:0] mem [int];

    blkcopy_engine i_blkcopy_engine (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mget(input logic [19:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'(a[7:0] + 8'(a[15:8] * 3) + 8'(a[19:16]) + 8'h5A);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder and scoreboard monitor
    int          wait_cnt = 0;
    int          lat_sel = 0;
    logic [19:0] hold_a;
    logic        hold_we;
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                hold_a  = mem_addr;
                hold_we = mem_we;
            end else begin
                check("R6 stalled request held", {11'd0, mem_we, mem_addr}, {11'd0, hold_we, hold_a});
            end
            if (wait_cnt >= (lat_sel % 3)) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected transaction", {11'd0, mem_we, mem_addr}, 32'hFFFF_FFFF);
                end else begin
                    txn_t e;
                    e = exp_q.pop_front();
                    check("R5 transaction kind/address", {11'd0, mem_we, mem_addr}, {11'd0, e.we, e.a});
                    if (e.we) check("R5 write data", {24'd0, mem_wdata}, {24'd0, e.d});
                end
                if (mem_we) mem[int'(mem_addr)] = mem_wdata;
                else        mem_rdata = mget(mem_addr);
                mem_ready = 1'b1;
                wait_cnt  = 0;
                lat_sel++;
            end else begin
                wait_cnt++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic cfg_wr(input logic [3:0] o, input logic [7:0] d);
        @(negedge clk);
        cfg_addr  = o;
        cfg_wdata = d;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic cfg_rd(input logic [3:0] o, output logic [7:0] d);
        cfg_addr = o;
        #1;
        d = cfg_rdata;
    endtask

    task automatic rd_check(input string tag, input logic [3:0] o, input logic [7:0] exp);
        logic [7:0] v;
        cfg_rd(o, v);
        check(tag, {24'd0, v}, {24'd0, exp});
    endtask

    task automatic setup(input logic [19:0] s, input logic [19:0] d, input logic [15:0] n);
        cfg_wr(4'd0, s[7:0]);
        cfg_wr(4'd1, s[15:8]);
        cfg_wr(4'd2, {4'd0, s[19:16]});
        cfg_wr(4'd4, d[7:0]);
        cfg_wr(4'd5, d[15:8]);
        cfg_wr(4'd3, {4'd0, d[19:16]});
        cfg_wr(4'd6, n[7:0]);
        cfg_wr(4'd7, n[15:8]);
    endtask

    // driver: pushes the expected transaction stream for one copy
    task automatic push_expect(input logic [19:0] s, input logic [19:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            txn_t r, w;
            r.we = 1'b0; r.a = 20'(s + 20'(i)); r.d = '0;
            w.we = 1'b1; w.a = 20'(d + 20'(i)); w.d = mget(r.a);
            exp_q.push_back(r);
            exp_q.push_back(w);
        end
    endtask

    task automatic wait_idle;
        logic [7:0] v;
        int n = 0;
        cfg_rd(4'd8, v);
        while (v != 8'h00 && n < 20000) begin
            @(negedge clk);
            cfg_rd(4'd8, v);
            n++;
        end
    endtask

    task automatic check_regs(input string tag, input logic [19:0] s, input logic [19:0] d);
        rd_check({tag, " src[7:0]"},  4'd0, s[7:0]);
        rd_check({tag, " src[15:8]"}, 4'd1, s[15:8]);
        rd_check({tag, " src bank"},  4'd2, {4'd0, s[19:16]});
        rd_check({tag, " dst bank"},  4'd3, {4'd0, d[19:16]});
        rd_check({tag, " dst[7:0]"},  4'd4, d[7:0]);
        rd_check({tag, " dst[15:8]"}, 4'd5, d[15:8]);
        rd_check({tag, " cnt lo"},    4'd6, 8'h00);
        rd_check({tag, " cnt hi"},    4'd7, 8'h00);
        rd_check({tag, " ctrl"},      4'd8, 8'h00);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 and R10: reset state of every offset
        for (int o = 0; o < 16; o++) rd_check(o < 9 ? "R1 reset value" : "R10 unused offset", 4'(o), 8'h00);
        check("R1 mem_req low after reset", {31'd0, mem_req}, 32'd0);

        // R2, R3: register map read-back
        setup(20'hF_ABCD, 20'hE_1234, 16'h5678);
        cfg_wr(4'd2, 8'hFF);
        cfg_wr(4'd3, 8'hF7);
        rd_check("R2 src[7:0]", 4'd0, 8'hCD);
        rd_check("R2 src[15:8]", 4'd1, 8'hAB);
        rd_check("R2 src bank upper bits zero", 4'd2, 8'h0F);
        rd_check("R3 dst bank upper bits zero", 4'd3, 8'h07);
        rd_check("R3 dst[7:0]", 4'd4, 8'h34);
        rd_check("R3 dst[15:8]", 4'd5, 8'h12);
        rd_check("R3 cnt lo", 4'd6, 8'h78);
        rd_check("R3 cnt hi", 4'd7, 8'h56);

        // R10: writes to unused offsets
        cfg_wr(4'd12, 8'h55);
        cfg_wr(4'd9, 8'hAA);
        rd_check("R10 offset 12 after write", 4'd12, 8'h00);
        rd_check("R10 offset 9 after write", 4'd9, 8'h00);
        rd_check("R10 src untouched", 4'd0, 8'hCD);

        // R4: control write without start bit
        cfg_wr(4'd8, 8'h7F);
        rd_check("R4 no start without bit 7", 4'd8, 8'h00);
        repeat (4) begin
            @(negedge clk);
            check("R4 no request without bit 7", {31'd0, mem_req}, 32'd0);
        end

        // R5, R7: plain copy within a bank
        setup(20'h1_2345, 20'h4_0000, 16'd5);
        push_expect(20'h1_2345, 20'h4_0000, 5);
        cfg_wr(4'd8, 8'h80);
        rd_check("R4 busy reads 0x80", 4'd8, 8'h80);
        wait_idle();
        check("R5 all transactions seen", exp_q.size(), 0);
        check_regs("R7 plain copy", 20'h1_234A, 20'h4_0005);

        // R7: chained copy reloads only the count
        cfg_wr(4'd6, 8'd3);
        push_expect(20'h1_234A, 20'h4_0005, 3);
        cfg_wr(4'd8, 8'h80);
        wait_idle();
        check("R5 chained transactions seen", exp_q.size(), 0);
        check_regs("R7 chained copy", 20'h1_234D, 20'h4_0008);

        // R5, R7: crossing the 16-bit boundary
        setup(20'h1_FFFE, 20'h2_FFFF, 16'd4);
        push_expect(20'h1_FFFE, 20'h2_FFFF, 4);
        cfg_wr(4'd8, 8'h80);
        wait_idle();
        check("R5 carry transactions seen", exp_q.size(), 0);
        check_regs("R7 bank kept on carry", 20'h1_0002, 20'h2_0003);

        // R9: writes and restart while busy are dropped
        setup(20'h0_0100, 20'h0_0800, 16'd20);
        push_expect(20'h0_0100, 20'h0_0800, 20);
        cfg_wr(4'd8, 8'h80);
        cfg_wr(4'd0, 8'hAA);
        cfg_wr(4'd6, 8'hFF);
        cfg_wr(4'd3, 8'h09);
        cfg_wr(4'd8, 8'h80);
        wait_idle();
        check("R9 transactions exactly as first start", exp_q.size(), 0);
        check_regs("R9 busy writes ignored", 20'h0_0114, 20'h0_0814);
        repeat (6) begin
            @(negedge clk);
            check("R9 no second copy", {31'd0, mem_req}, 32'd0);
        end

        // R8: zero count
        setup(20'h0_0050, 20'h0_0060, 16'd0);
        cfg_wr(4'd8, 8'h80);
        rd_check("R8 busy for one cycle", 4'd8, 8'h80);
        check("R8 no request on zero count", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        rd_check("R8 control cleared", 4'd8, 8'h00);
        check("R8 still no request", {31'd0, mem_req}, 32'd0);
        check_regs("R8 addresses unchanged", 20'h0_0050, 20'h0_0060);

        repeat (4) @(negedge clk);
        check("R5 no leftover expected items", exp_q.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule